// File: doc/BRIEF.md
# Synchronous 68K-to-ISA Bus Bridge

This block sits between a processor bus that is sized dynamically, works big-endian and ends each transfer with a two-line size acknowledge (DSACK), and a little-endian 16-bit peripheral bus. On the peripheral side each command strobe is held for a fixed time and can be stretched by the ready line. One clock paces the whole controller. A host cycle starts when the address strobe falls while exactly one of two decoded region selects is active. The block then drives one of four active-low command strobes: memory read, memory write, I/O read or I/O write. The strobe is held for a base length of two clocks, and longer while the peripheral keeps its ready input low.

When the command ends, the bridge looks at the peripheral's 16-bit indicator for the active space. It then answers the host with the DSACK encoding for an 8-bit or a 16-bit port. A build option can insert one settling clock before the acknowledge. The acknowledge is held until the host releases the address strobe. Address, data lanes and interrupt requests go through combinational mapping: I/O addresses are cut to 16 bits, the byte lanes are swapped for a 16-bit or 32-bit host bus, and the active-high peripheral interrupts are inverted for the host.

Top module: `isa_bridge_top`

## Requirements
- R1: With `io_sel_n` low the cycle drives `ior_n` (rw=1) or `iow_n` (rw=0); with `mem_sel_n` low it drives `memr_n` or `memw_n`. At most one strobe is low at any time.
- R2: A command strobe falls one clock after the start condition is sampled and stays low for exactly two clocks when `iochrdy` is high.
- R3: While `iochrdy` is sampled low at the last base clock or later, the strobe stays low one more clock each time. The cycle ends only after `iochrdy` is seen high.
- R4: The port width is sampled on the last command clock, from `iocs16_n` for I/O and from `memcs16_n` for memory (low means 16-bit). A 16-bit port gets `dsack1_n` low with `dsack0_n` high. An 8-bit port gets `dsack0_n` low with `dsack1_n` high. The two lines are never low together.
- R5: With DSACK_DELAY=0 the acknowledge falls on the clock after the strobe rises. With DSACK_DELAY=1 it falls one clock later.
- R6: The acknowledge stays asserted while `as_n` is low. It is released on the first clock that samples `as_n` high.
- R7: No cycle starts unless `as_n` is low and exactly one select is low. With both selects low, no strobe and no acknowledge appear.
- R8: `bale` is constantly 1, `aen` is constantly 0, and `sbhe_n` follows `siz0`.
- R9: On memory cycles `isa_addr` equals the 24-bit host address. On I/O cycles bits 23:16 are zero (bit 16 included) and bits 15:0 pass through.
- R10: For HOST_DW=16, ISA D15:8 connects to host D7:0 and ISA D7:0 to host D15:8. For HOST_DW=32, ISA D7:0 connects to host D31:24, ISA D15:8 to host D23:16, and host read bits 15:0 are zero.
- R11: Each `irq_n` bit is the inverse of the matching `isa_irq` bit.
- R12: During and straight after reset, all four strobes and both acknowledge lines are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | bridge clock |
| rst_n | input | 1 | active-low reset |
| as_n | input | 1 | host address strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| siz0 | input | 1 | host size bit 0 |
| io_sel_n | input | 1 | decoded I/O region select, active low |
| mem_sel_n | input | 1 | decoded memory region select, active low |
| host_addr | input | 24 | host address |
| host_wdata | input | HOST_DW | host write data |
| host_rdata | output | HOST_DW | read data presented to host |
| isa_addr | output | 24 | peripheral address |
| isa_wdata | output | 16 | peripheral write data |
| isa_rdata | input | 16 | peripheral read data |
| memr_n | output | 1 | memory read strobe |
| memw_n | output | 1 | memory write strobe |
| ior_n | output | 1 | I/O read strobe |
| iow_n | output | 1 | I/O write strobe |
| bale | output | 1 | address latch enable, fixed high |
| aen | output | 1 | address enable for DMA, fixed low |
| sbhe_n | output | 1 | high byte enable |
| iochrdy | input | 1 | peripheral ready, low stretches |
| iocs16_n | input | 1 | I/O port is 16-bit, active low |
| memcs16_n | input | 1 | memory port is 16-bit, active low |
| dsack0_n | output | 1 | host acknowledge line 0 |
| dsack1_n | output | 1 | host acknowledge line 1 |
| isa_irq | input | IRQ_N | peripheral interrupts, active high |
| irq_n | output | IRQ_N | host interrupts, active low |

## Verification
Two things fall on one clock edge: the end of a stretch and the capture of the port width. The edge that first samples `iochrdy` high is the edge that latches the width indicator. The bench sweeps stretch lengths of zero to three clocks and crosses them with both widths, both spaces and both directions. For each case it judges the strobe length in clocks and the acknowledge encoding. Two instances share the stimulus, one with the settling clock and one without, and their acknowledge edges must differ by exactly one clock.

// File: rtl/isa_bridge_pkg.sv
package isa_bridge_pkg;
    typedef enum logic [1:0] {
        BR_IDLE   = 2'd0,
        BR_CMD    = 2'd1,
        BR_SETTLE = 2'd2,
        BR_ACK    = 2'd3
    } br_state_e;
endpackage

// File: rtl/isa_cycle_fsm.sv
module isa_cycle_fsm
    import isa_bridge_pkg::*;
#(
    parameter int BASE_CLKS   = 2,
    parameter bit DSACK_DELAY = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic as_n,
    input  logic rw,
    input  logic io_sel_n,
    input  logic mem_sel_n,
    input  logic iochrdy,
    input  logic iocs16_n,
    input  logic memcs16_n,
    output logic memr_n,
    output logic memw_n,
    output logic ior_n,
    output logic iow_n,
    output logic dsack0_n,
    output logic dsack1_n
);
    localparam int CW = (BASE_CLKS > 2) ? $clog2(BASE_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(BASE_CLKS - 1);

    typedef struct packed {
        br_state_e     st;
        logic [CW-1:0] cnt;
        logic          io;
        logic          rd;
        logic          wide;
    } fsm_t;

    fsm_t r_d, r_q;
    logic start_ok;

    assign start_ok = !as_n && (io_sel_n ^ mem_sel_n);

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            BR_IDLE: begin
                if (start_ok) begin
                    r_d.st  = BR_CMD;
                    r_d.cnt = '0;
                    r_d.io  = !io_sel_n;
                    r_d.rd  = rw;
                end
            end
            BR_CMD: begin
                if (r_q.cnt != LAST) begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end else if (iochrdy) begin
                    r_d.wide = r_q.io ? !iocs16_n : !memcs16_n;
                    r_d.st   = DSACK_DELAY ? BR_SETTLE : BR_ACK;
                end
            end
            BR_SETTLE: r_d.st = BR_ACK;
            BR_ACK: begin
                if (as_n) r_d.st = BR_IDLE;
            end
            default: r_d.st = BR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: BR_IDLE, cnt: '0, io: 1'b0, rd: 1'b0, wide: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    logic in_cmd, in_ack;
    assign in_cmd = (r_q.st == BR_CMD);
    assign in_ack = (r_q.st == BR_ACK);

    assign memr_n   = !(in_cmd && !r_q.io &&  r_q.rd);
    assign memw_n   = !(in_cmd && !r_q.io && !r_q.rd);
    assign ior_n    = !(in_cmd &&  r_q.io &&  r_q.rd);
    assign iow_n    = !(in_cmd &&  r_q.io && !r_q.rd);
    assign dsack1_n = !(in_ack &&  r_q.wide);
    assign dsack0_n = !(in_ack && !r_q.wide);

    logic all_hi;
    assign all_hi = memr_n & memw_n & ior_n & iow_n;

    // R1
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!memr_n, !memw_n, !ior_n, !iow_n}));

    // R2
    min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(all_hi) |=> !all_hi);

    // R4
    dsack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dsack0_n && !dsack1_n));

    // R6
    dsack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!dsack0_n || !dsack1_n) && !as_n) |=> $stable({dsack0_n, dsack1_n}));

    // R7
    dual_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (all_hi && dsack0_n && dsack1_n && !io_sel_n && !mem_sel_n) |=> all_hi);
endmodule

// File: rtl/isa_addr_map.sv
module isa_addr_map #(
    parameter int AW    = 24,
    parameter int IO_AW = 16
) (
    input  logic          io_sel_n,
    input  logic [AW-1:0] host_addr,
    output logic [AW-1:0] isa_addr
);
    localparam int HI_W = AW - IO_AW;

    always_comb begin
        isa_addr = host_addr;
        if (!io_sel_n) isa_addr[AW-1:IO_AW] = '0;
    end

    // R9
    always_comb begin
        if (!io_sel_n) io_high_zero_chk: assert (isa_addr[AW-1 -: HI_W] == '0);
    end
endmodule

// File: rtl/isa_lane_swap.sv
module isa_lane_swap #(
    parameter int HOST_DW = 16
) (
    input  logic [HOST_DW-1:0] host_wdata,
    output logic [HOST_DW-1:0] host_rdata,
    output logic [15:0]        isa_wdata,
    input  logic [15:0]        isa_rdata
);
    generate
        if (HOST_DW == 32) begin : g_w32
            logic unused_low;
            assign unused_low = ^host_wdata[15:0];
            assign isa_wdata  = {host_wdata[23:16], host_wdata[31:24]};
            assign host_rdata = {isa_rdata[7:0], isa_rdata[15:8], 16'h0000};
        end else begin : g_w16
            assign isa_wdata  = {host_wdata[7:0], host_wdata[15:8]};
            assign host_rdata = {isa_rdata[7:0], isa_rdata[15:8]};
        end
    endgenerate
endmodule

// File: rtl/isa_irq_invert.sv
module isa_irq_invert #(
    parameter int IRQ_N = 4
) (
    input  logic [IRQ_N-1:0] isa_irq,
    output logic [IRQ_N-1:0] irq_n
);
    for (genvar i = 0; i < IRQ_N; i++) begin : g_inv
        assign irq_n[i] = ~isa_irq[i];
    end
endmodule

// File: rtl/isa_bridge_top.sv
module isa_bridge_top #(
    parameter int HOST_DW     = 16,
    parameter int IRQ_N       = 4,
    parameter int BASE_CLKS   = 2,
    parameter bit DSACK_DELAY = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               as_n,
    input  logic               rw,
    input  logic               siz0,
    input  logic               io_sel_n,
    input  logic               mem_sel_n,
    input  logic [23:0]        host_addr,
    input  logic [HOST_DW-1:0] host_wdata,
    output logic [HOST_DW-1:0] host_rdata,
    output logic [23:0]        isa_addr,
    output logic [15:0]        isa_wdata,
    input  logic [15:0]        isa_rdata,
    output logic               memr_n,
    output logic               memw_n,
    output logic               ior_n,
    output logic               iow_n,
    output logic               bale,
    output logic               aen,
    output logic               sbhe_n,
    input  logic               iochrdy,
    input  logic               iocs16_n,
    input  logic               memcs16_n,
    output logic               dsack0_n,
    output logic               dsack1_n,
    input  logic [IRQ_N-1:0]   isa_irq,
    output logic [IRQ_N-1:0]   irq_n
);
    assign bale   = 1'b1;
    assign aen    = 1'b0;
    assign sbhe_n = siz0;

    isa_cycle_fsm #(.BASE_CLKS(BASE_CLKS), .DSACK_DELAY(DSACK_DELAY)) u_fsm (
        .clk(clk), .rst_n(rst_n), .as_n(as_n), .rw(rw),
        .io_sel_n(io_sel_n), .mem_sel_n(mem_sel_n),
        .iochrdy(iochrdy), .iocs16_n(iocs16_n), .memcs16_n(memcs16_n),
        .memr_n(memr_n), .memw_n(memw_n), .ior_n(ior_n), .iow_n(iow_n),
        .dsack0_n(dsack0_n), .dsack1_n(dsack1_n)
    );

    isa_addr_map #(.AW(24), .IO_AW(16)) u_addr (
        .io_sel_n(io_sel_n), .host_addr(host_addr), .isa_addr(isa_addr)
    );

    isa_lane_swap #(.HOST_DW(HOST_DW)) u_lane (
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .isa_wdata(isa_wdata), .isa_rdata(isa_rdata)
    );

    isa_irq_invert #(.IRQ_N(IRQ_N)) u_irq (
        .isa_irq(isa_irq), .irq_n(irq_n)
    );
endmodule

// File: tb/sim_isa_bridge_top.sv
`timescale 1ns/1ps
module sim_isa_bridge_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic as_n = 1'b1, rw = 1'b1, siz0 = 1'b0;
    logic io_sel_n = 1'b1, mem_sel_n = 1'b1;
    logic [23:0] host_addr = '0;
    logic [15:0] hw16 = '0;
    logic [31:0] hw32 = '0;
    logic [15:0] isa_rdata = '0;
    logic iochrdy = 1'b1, iocs16_n = 1'b1, memcs16_n = 1'b1;
    logic [3:0] isa_irq = '0;

    logic [15:0] hr16, iw16, iw32;
    logic [31:0] hr32;
    logic [23:0] ia0, ia1;
    logic mr0, mw0, ir0, iw0, bale0, aen0, sb0, d00, d10;
    logic mr1, mw1, ir1, iw1, bale1, aen1, sb1, d01, d11;
    logic [3:0] irqn0, irqn1;

    int checks = 0, fails = 0;

    isa_bridge_top #(.HOST_DW(16), .IRQ_N(4), .BASE_CLKS(2), .DSACK_DELAY(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .as_n(as_n), .rw(rw), .siz0(siz0),
        .io_sel_n(io_sel_n), .mem_sel_n(mem_sel_n), .host_addr(host_addr),
        .host_wdata(hw16), .host_rdata(hr16), .isa_addr(ia0), .isa_wdata(iw16),
        .isa_rdata(isa_rdata), .memr_n(mr0), .memw_n(mw0), .ior_n(ir0), .iow_n(iw0),
        .bale(bale0), .aen(aen0), .sbhe_n(sb0), .iochrdy(iochrdy),
        .iocs16_n(iocs16_n), .memcs16_n(memcs16_n), .dsack0_n(d00), .dsack1_n(d10),
        .isa_irq(isa_irq), .irq_n(irqn0)
    );

    isa_bridge_top #(.HOST_DW(32), .IRQ_N(4), .BASE_CLKS(2), .DSACK_DELAY(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .as_n(as_n), .rw(rw), .siz0(siz0),
        .io_sel_n(io_sel_n), .mem_sel_n(mem_sel_n), .host_addr(host_addr),
        .host_wdata(hw32), .host_rdata(hr32), .isa_addr(ia1), .isa_wdata(iw32),
        .isa_rdata(isa_rdata), .memr_n(mr1), .memw_n(mw1), .ior_n(ir1), .iow_n(iw1),
        .bale(bale1), .aen(aen1), .sbhe_n(sb1), .iochrdy(iochrdy),
        .iocs16_n(iocs16_n), .memcs16_n(memcs16_n), .dsack0_n(d01), .dsack1_n(d11),
        .isa_irq(isa_irq), .irq_n(irqn1)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        checks++; fails++;
        $display("FAIL watchdog actual=1 expected=0");
        summary();
    end

    // one host cycle: io space?, read?, 16-bit port?, stretch clocks
    task automatic run_cycle(input bit io, input bit rd, input bit wide, input int wt);
        logic [3:0] exp_low;
        int k = 0, i0 = 0, i1 = 0;
        exp_low = {io & !rd, io & rd, !io & !rd, !io & rd}; // {iow,ior,memw,memr}
        @(negedge clk);
        rw = rd; siz0 = wt[0];
        io_sel_n = !io; mem_sel_n = io;
        iocs16_n = !(io && wide); memcs16_n = !(!io && wide);
        iochrdy = 1'b0;
        as_n = 1'b0;
        for (int i = 1; i <= 40 && i1 == 0; i++) begin
            @(negedge clk);
            if ({iw0, ir0, mw0, mr0} != 4'hF) begin
                k++;
                // R1
                chk({iw0, ir0, mw0, mr0} == ~exp_low, "R1", {iw0, ir0, mw0, mr0}, ~exp_low);
            end
            iochrdy = (k >= 2 + wt);
            if (i0 == 0 && !(d00 && d10)) i0 = i;
            if (i1 == 0 && !(d01 && d11)) i1 = i;
        end
        // R2 R3
        chk(k == 2 + wt, wt == 0 ? "R2" : "R3", k, 2 + wt);
        // R4
        chk({d10, d00} == (wide ? 2'b01 : 2'b10), "R4", {d10, d00}, wide ? 2'b01 : 2'b10);
        chk({d11, d01} == (wide ? 2'b01 : 2'b10), "R4", {d11, d01}, wide ? 2'b01 : 2'b10);
        // R5
        chk(i0 == 3 + wt, "R5", i0, 3 + wt);
        chk(i1 == i0 + 1, "R5", i1, i0 + 1);
        // R8
        chk(sb0 == siz0 && bale0 && !aen0, "R8", {bale0, aen0, sb0}, {2'b10, siz0});
        @(negedge clk);
        // R6 held while strobe low
        chk(!(d00 && d10) && !(d01 && d11), "R6", {d10, d00, d11, d01}, 0);
        as_n = 1'b1;
        @(negedge clk);
        chk(d00 && d10 && d01 && d11, "R6", {d10, d00, d11, d01}, 4'hF);
        io_sel_n = 1'b1; mem_sel_n = 1'b1; iochrdy = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R12
        chk({mr0, mw0, ir0, iw0, d00, d10} == 6'h3F, "R12", {mr0, mw0, ir0, iw0, d00, d10}, 6'h3F);
        rst_n = 1'b1;
        @(negedge clk);
        chk({mr1, mw1, ir1, iw1, d01, d11} == 6'h3F, "R12", {mr1, mw1, ir1, iw1, d01, d11}, 6'h3F);

        for (int c = 0; c < 32; c++) begin
            run_cycle(c[0], c[1], c[2], c[4:3]);
        end

        // R7: both selects low
        @(negedge clk);
        io_sel_n = 1'b0; mem_sel_n = 1'b0; as_n = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk({mr0, mw0, ir0, iw0, d00, d10, mr1, mw1, ir1, iw1, d01, d11} == 12'hFFF,
                "R7", {mr0, mw0, ir0, iw0, d00, d10}, 6'h3F);
        end
        as_n = 1'b1; io_sel_n = 1'b1; mem_sel_n = 1'b1;
        @(negedge clk);

        // R9 R10 R11 sweeps
        for (int a = 0; a < 64; a++) begin
            logic [23:0] addr;
            logic [15:0] rdv;
            logic [31:0] w32;
            addr = 24'h123457 * (a + 1) ^ {a[5:0], 18'h2A5A5};
            rdv  = 16'h9C31 * (a + 3);
            w32  = 32'hA5C3_0F1E ^ (32'h01010101 * a);
            host_addr = addr; isa_rdata = rdv; hw16 = w32[15:0]; hw32 = w32;
            isa_irq = a[3:0];
            io_sel_n = a[0];
            #1;
            if (a[0]) chk(ia0 == addr, "R9", ia0, addr);
            else chk(ia0 == {8'h00, addr[15:0]}, "R9", ia0, {8'h00, addr[15:0]});
            chk(iw16 == {w32[7:0], w32[15:8]}, "R10", iw16, {w32[7:0], w32[15:8]});
            chk(hr16 == {rdv[7:0], rdv[15:8]}, "R10", hr16, {rdv[7:0], rdv[15:8]});
            chk(iw32 == {w32[23:16], w32[31:24]}, "R10", iw32, {w32[23:16], w32[31:24]});
            chk(hr32 == {rdv[7:0], rdv[15:8], 16'h0}, "R10", hr32, {rdv[7:0], rdv[15:8], 16'h0});
            chk(irqn0 == ~a[3:0] && irqn1 == ~a[3:0], "R11", irqn0, ~a[3:0]);
        end
        io_sel_n = 1'b1;
        summary();
    end
endmodule